// File: doc/BRIEF.md
# Clock synthesizer channel configuration bank

This block holds the software-visible settings of a four-output fractional clock synthesizer that shares one multiplying PLL. A processor reaches it over a plain word-addressed bus: one write strobe, a word address, 32-bit write data and a combinational read-data return. Each channel has a parameter word made of a fine phase step, a coarse divider, a power-of-two post divider and a divide-by-3 bypass flag. A write to that word only fills a staging copy. The values the synthesizer datapath sees come from a separate active copy.

The active copy of a channel is reloaded from its staging copy only when software raises that channel's program-enable bit from 0 to 1. Software can therefore retune a running output without the datapath ever seeing a half-written set of parameters. A shared control word drives the per-channel reset lines, the active-low per-channel standby lines and the PLL power-down line, and it returns the PLL lock input as a read-only bit. A separate word sets the PLL multiplier, whose effective factor is the field value plus 16.

Word map: 0 shared control, 1 PLL multiplier, 2 program enable, 4 to 7 parameter words of channels 0 to 3. Address 3 is unused.

Top module: `fsyn_cfg_bank`

## Requirements
- R1: After reset every register and active parameter is zero, every output is zero except the PLL factor, which is 16, and every word reads as zero while the lock input is low.
- R2: A channel parameter word places the fine phase step in bits 14:0, the coarse divider in 19:15, the power-of-two divider in 23:20 and the divide-by-3 bypass flag in bit 24. A read returns the staged value, with bits 31:25 reading zero.
- R3: Writing a channel's parameter word never changes that channel's active outputs.
- R4: A write to the program-enable word that changes a channel's bit from 0 to 1 copies that channel's full staged word into its active outputs at that clock edge, so the new values are visible in the cycle after the write.
- R5: A channel whose program-enable bit is already 1 and is written with 1 again takes no new copy. Clearing the bit takes no copy either, and a later 0-to-1 change copies again.
- R6: In the shared control word, bits 3:0 drive the channel reset outputs, bits 11:8 drive the active-low standby outputs (0 means standby) and bit 12 drives the PLL power-down output. All of these read back in place.
- R7: Bit 24 of the shared control word reads the current PLL lock input. A write to that bit is ignored.
- R8: Bits 18:16 of the multiplier word hold the multiplier field and read back in place. The PLL factor output equals the field plus 16.
- R9: Each channel's divide-by-3 select output equals the active bypass flag: 0 applies divide by 3 and 1 bypasses it.
- R10: The program-enable word reads back bits 3:0. A write to address 3 changes no output, and that address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| pll_lock | input | 1 | Lock indication from the PLL |
| ch_rst | output | 4 | Per-channel reset |
| ch_sb_n | output | 4 | Per-channel standby, active low |
| ch_div3_n | output | 4 | Per-channel divide-by-3 bypass (0 divides by 3) |
| ch_fine | output | 60 | Active fine phase steps, 15 bits per channel |
| ch_coarse | output | 20 | Active coarse dividers, 5 bits per channel |
| ch_pow2 | output | 16 | Active power-of-two dividers, 4 bits per channel |
| pll_pd | output | 1 | PLL power-down |
| pll_mult | output | 5 | Effective PLL multiplication factor |

## Verification
A single program-enable write can load one channel and leave another alone in the same clock edge. The first channel sees its bit rise from 0 to 1, while the second already holds 1 and has had a fresh value staged behind it. The bench sets up that case by raising channel 0's bit, staging new words for channels 0 and 1, and then writing both bits as 1. It then expects channel 1 to show its new word and channel 0 to keep its old one. A bench model of staged words, active words and enable bits predicts every channel after each write, and a separate test confirms that a later 0-to-1 change on channel 0 finally loads the word that was held back.

// File: rtl/fsyn_cfg_pkg.sv
package fsyn_cfg_pkg;

    localparam int FINE_W    = 15;
    localparam int COARSE_W  = 5;
    localparam int POW2_W    = 4;
    localparam int MULT_W    = 3;
    localparam int MULT_BASE = 16;
    localparam int FACT_W    = 5;

    // Bit positions inside the shared words
    localparam int CTL_SB_LSB   = 8;
    localparam int CTL_PD_BIT   = 12;
    localparam int CTL_LOCK_BIT = 24;
    localparam int MULT_LSB     = 16;

    // Word addresses
    localparam int ADR_CTRL = 0;
    localparam int ADR_MULT = 1;
    localparam int ADR_PGM  = 2;
    localparam int ADR_CH0  = 4;

    // Channel parameter word, MSB first: bypass(24) pow2(23:20) coarse(19:15) fine(14:0)
    typedef struct packed {
        logic                div3_n;
        logic [POW2_W-1:0]   pow2;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } chan_par_t;

    localparam int PAR_W = $bits(chan_par_t);

endpackage

// File: rtl/fsyn_chan_slot.sv
module fsyn_chan_slot
    import fsyn_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stage_we,
    input  chan_par_t stage_in,
    input  logic      commit,
    output chan_par_t stage_o,
    output chan_par_t act_o
);

    typedef struct packed {
        chan_par_t stg;
        chan_par_t act;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (stage_we) begin
            slot_d.stg = stage_in;
        end
        if (commit) begin
            slot_d.act = slot_q.stg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign stage_o = slot_q.stg;
    assign act_o   = slot_q.act;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_o))
        else $error("active set moved without a commit");

    assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_o == $past(stage_o)))
        else $error("commit did not load the staged word");

endmodule

// File: rtl/fsyn_ctl_regs.sv
module fsyn_ctl_regs
    import fsyn_cfg_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_mult,
    input  logic              wr_pgm,
    input  logic [NCH-1:0]    rst_in,
    input  logic [NCH-1:0]    sbn_in,
    input  logic              pd_in,
    input  logic [MULT_W-1:0] mult_in,
    input  logic [NCH-1:0]    pgm_in,
    output logic [NCH-1:0]    rst_o,
    output logic [NCH-1:0]    sbn_o,
    output logic              pd_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [NCH-1:0]    pgm_o,
    output logic [NCH-1:0]    commit_o
);

    typedef struct packed {
        logic [NCH-1:0]    rst;
        logic [NCH-1:0]    sbn;
        logic              pd;
        logic [MULT_W-1:0] mult;
        logic [NCH-1:0]    pgm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) begin
            ctl_d.rst = rst_in;
            ctl_d.sbn = sbn_in;
            ctl_d.pd  = pd_in;
        end
        if (wr_mult) begin
            ctl_d.mult = mult_in;
        end
        if (wr_pgm) begin
            ctl_d.pgm = pgm_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // A channel loads only on a 0-to-1 change of its enable bit
    assign commit_o = wr_pgm ? (pgm_in & ~ctl_q.pgm) : '0;

    assign rst_o  = ctl_q.rst;
    assign sbn_o  = ctl_q.sbn;
    assign pd_o   = ctl_q.pd;
    assign mult_o = ctl_q.mult;
    assign pgm_o  = ctl_q.pgm;

endmodule

// File: rtl/fsyn_cfg_bank.sv
module fsyn_cfg_bank
    import fsyn_cfg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   pll_lock,
    output logic [NCH-1:0]         ch_rst,
    output logic [NCH-1:0]         ch_sb_n,
    output logic [NCH-1:0]         ch_div3_n,
    output logic [NCH*FINE_W-1:0]  ch_fine,
    output logic [NCH*COARSE_W-1:0] ch_coarse,
    output logic [NCH*POW2_W-1:0]  ch_pow2,
    output logic                   pll_pd,
    output logic [FACT_W-1:0]      pll_mult
);

    localparam int CH_END = ADR_CH0 + NCH;

    logic              wr_ctl, wr_mult, wr_pgm;
    logic [NCH-1:0]    stage_we;
    logic [NCH-1:0]    commit;
    logic [NCH-1:0]    rst_r, sbn_r, pgm_r;
    logic              pd_r;
    logic [MULT_W-1:0] mult_r;
    chan_par_t         stage_q [NCH];
    chan_par_t         act_q   [NCH];
    chan_par_t         wpar;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:25], bus_wdata[23:19], bus_wdata[15:13],
                            bus_wdata[7:NCH]};
    assign wpar = chan_par_t'(bus_wdata[PAR_W-1:0]);

    always_comb begin
        wr_ctl   = bus_wr && (int'(bus_addr) == ADR_CTRL);
        wr_mult  = bus_wr && (int'(bus_addr) == ADR_MULT);
        wr_pgm   = bus_wr && (int'(bus_addr) == ADR_PGM);
        stage_we = '0;
        for (int i = 0; i < NCH; i++) begin
            stage_we[i] = bus_wr && (int'(bus_addr) == ADR_CH0 + i);
        end
    end

    fsyn_ctl_regs #(.NCH(NCH)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_ctl),
        .wr_mult  (wr_mult),
        .wr_pgm   (wr_pgm),
        .rst_in   (bus_wdata[NCH-1:0]),
        .sbn_in   (bus_wdata[CTL_SB_LSB +: NCH]),
        .pd_in    (bus_wdata[CTL_PD_BIT]),
        .mult_in  (bus_wdata[MULT_LSB +: MULT_W]),
        .pgm_in   (bus_wdata[NCH-1:0]),
        .rst_o    (rst_r),
        .sbn_o    (sbn_r),
        .pd_o     (pd_r),
        .mult_o   (mult_r),
        .pgm_o    (pgm_r),
        .commit_o (commit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        fsyn_chan_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .stage_we (stage_we[g]),
            .stage_in (wpar),
            .commit   (commit[g]),
            .stage_o  (stage_q[g]),
            .act_o    (act_q[g])
        );

        assign ch_fine[g*FINE_W +: FINE_W]       = act_q[g].fine;
        assign ch_coarse[g*COARSE_W +: COARSE_W] = act_q[g].coarse;
        assign ch_pow2[g*POW2_W +: POW2_W]       = act_q[g].pow2;
        assign ch_div3_n[g]                      = act_q[g].div3_n;

        // An enable bit already at 1 cannot rise at the next edge
        assert_held_no_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pgm_r[g] |=> $stable(act_q[g]))
            else $error("channel reloaded while its enable stayed high");

        assert_rise_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pgm_r[g]) |-> (act_q[g] == $past(stage_q[g])))
            else $error("enable rose without loading the staged word");
    end

    assign ch_rst   = rst_r;
    assign ch_sb_n  = sbn_r;
    assign pll_pd   = pd_r;
    assign pll_mult = FACT_W'(mult_r) + FACT_W'(MULT_BASE);

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == ADR_CTRL) begin
            bus_rdata[NCH-1:0]              = rst_r;
            bus_rdata[CTL_SB_LSB +: NCH]    = sbn_r;
            bus_rdata[CTL_PD_BIT]           = pd_r;
            bus_rdata[CTL_LOCK_BIT]         = pll_lock;
        end else if (int'(bus_addr) == ADR_MULT) begin
            bus_rdata[MULT_LSB +: MULT_W]   = mult_r;
        end else if (int'(bus_addr) == ADR_PGM) begin
            bus_rdata[NCH-1:0]              = pgm_r;
        end else if (int'(bus_addr) >= ADR_CH0 && int'(bus_addr) < CH_END) begin
            for (int i = 0; i < NCH; i++) begin
                if (int'(bus_addr) == ADR_CH0 + i) begin
                    bus_rdata[PAR_W-1:0] = stage_q[i];
                end
            end
        end
    end

    assert_mult_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mult >= FACT_W'(MULT_BASE)) && (pll_mult <= FACT_W'(MULT_BASE + 7)))
        else $error("PLL factor out of range");

endmodule

// File: tb/fsyn_cfg_bank_test.sv
module fsyn_cfg_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        pll_lock = 0;
    logic [3:0]  ch_rst, ch_sb_n, ch_div3_n;
    logic [59:0] ch_fine;
    logic [19:0] ch_coarse;
    logic [15:0] ch_pow2;
    logic        pll_pd;
    logic [4:0]  pll_mult;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [24:0] m_stg [NCH];
    logic [24:0] m_act [NCH];
    logic [3:0]  m_pgm;

    fsyn_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
        .ch_rst(ch_rst), .ch_sb_n(ch_sb_n), .ch_div3_n(ch_div3_n),
        .ch_fine(ch_fine), .ch_coarse(ch_coarse), .ch_pow2(ch_pow2),
        .pll_pd(pll_pd), .pll_mult(pll_mult)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = d;
        bus_wr    = 1;
        @(posedge clk);
        #1;
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [24:0] act_of(input int i);
        return {ch_div3_n[i], ch_pow2[i*4 +: 4], ch_coarse[i*5 +: 5], ch_fine[i*15 +: 15]};
    endfunction

    task automatic stage(input int ch, input logic [31:0] d);
        wr(4 + ch, d);
        m_stg[ch] = d[24:0];
    endtask

    task automatic pgm(input logic [3:0] v);
        wr(2, {28'h0, v});
        for (int i = 0; i < NCH; i++) begin
            if (v[i] && !m_pgm[i]) m_act[i] = m_stg[i];
        end
        m_pgm = v;
    endtask

    task automatic check_acts(input string req);
        for (int i = 0; i < NCH; i++) begin
            chk(req, {7'h0, act_of(i)}, {7'h0, m_act[i]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pat;
        logic [3:0]  snap_rst, snap_sb;
        logic        snap_pd;
        logic [4:0]  snap_mult;
        for (int i = 0; i < NCH; i++) begin
            m_stg[i] = '0;
            m_act[i] = '0;
        end
        m_pgm = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 ch_rst", {28'h0, ch_rst}, 32'h0);
        chk("R1 ch_sb_n", {28'h0, ch_sb_n}, 32'h0);
        chk("R1 pll_pd", {31'h0, pll_pd}, 32'h0);
        chk("R1 pll_mult", {27'h0, pll_mult}, 32'd16);
        check_acts("R1 active");
        @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 8; a++) begin
            rd(a, r);
            chk("R1 readback", r, 32'h0);
        end

        // R8: multiplier sweep, other bits carry junk
        for (int v = 0; v < 8; v++) begin
            wr(1, 32'hFFF8_FFFF | (32'(v) << 16));
            chk("R8 factor", {27'h0, pll_mult}, 32'(v + 16));
            rd(1, r);
            chk("R8 readback", r, 32'(v) << 16);
        end

        // R6: shared control sweep; lock bit written 1 must be ignored (R7)
        for (int k = 0; k < 512; k++) begin
            pat = {7'h0, 1'b1, 11'h0, k[8], k[7:4], 4'h0, k[3:0]};
            wr(0, pat | 32'hFE00_E0F0);
            chk("R6 ch_rst", {28'h0, ch_rst}, {28'h0, 4'(k)});
            chk("R6 ch_sb_n", {28'h0, ch_sb_n}, {28'h0, 4'(k >> 4)});
            chk("R6 pll_pd", {31'h0, pll_pd}, {31'h0, k[8]});
            rd(0, r);
            chk("R7 write to lock ignored", r, pat & 32'h0000_1F0F);
        end

        // R7: lock input visible at bit 24
        pll_lock = 1;
        rd(0, r);
        chk("R7 lock set", r, 32'h0100_1F0F);
        pll_lock = 0;
        rd(0, r);
        chk("R7 lock clear", r, 32'h0000_1F0F);

        // R2, R3, R4, R9: per-channel staging then load
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 0; p < 6; p++) begin
                pat = (32'(ch) * 32'h0013_579B + 32'(p) * 32'h0246_8ACF) ^ (p == 5 ? 32'hFFFF_FFFF : 32'h0);
                stage(ch, pat);
                rd(4 + ch, r);
                chk("R2 staged readback", r, {7'h0, pat[24:0]});
                check_acts("R3 staging leaves active");
                pgm(4'(1 << ch));
                check_acts("R4 load on rise");
                chk("R2 fine field", {17'h0, ch_fine[ch*15 +: 15]}, {17'h0, pat[14:0]});
                chk("R2 coarse field", {27'h0, ch_coarse[ch*5 +: 5]}, {27'h0, pat[19:15]});
                chk("R2 pow2 field", {28'h0, ch_pow2[ch*4 +: 4]}, {28'h0, pat[23:20]});
                chk("R9 divide-by-3 select", {31'h0, ch_div3_n[ch]}, {31'h0, pat[24]});
                rd(2, r);
                chk("R10 enable readback", r, 32'(1 << ch));
                pgm(4'h0);
                check_acts("R5 clearing takes no copy");
            end
        end

        // R5: one write loads channel 1 while channel 0 is held
        pgm(4'b0001);
        stage(0, 32'h00AB_CDEF);
        stage(1, 32'h0135_7246);
        pgm(4'b0011);
        check_acts("R5 mixed rise and hold");
        chk("R5 channel 0 held", {7'h0, act_of(0)}, {7'h0, m_act[0]});
        stage(1, 32'h0055_AA55);
        pgm(4'b0011);
        check_acts("R5 rewrite of ones");
        pgm(4'b0000);
        pgm(4'b0001);
        chk("R5 reload after clear", {7'h0, act_of(0)}, 32'h00AB_CDEF);
        check_acts("R5 reload all");

        // R10: unused address
        snap_rst = ch_rst; snap_sb = ch_sb_n; snap_pd = pll_pd; snap_mult = pll_mult;
        wr(3, 32'hFFFF_FFFF);
        rd(3, r);
        chk("R10 unused reads zero", r, 32'h0);
        chk("R10 ctrl outputs kept", {23'h0, snap_pd, snap_sb, snap_rst}, {23'h0, pll_pd, ch_sb_n, ch_rst});
        chk("R10 factor kept", {27'h0, pll_mult}, {27'h0, snap_mult});
        check_acts("R10 active kept");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule